// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block keeps recently completed address translations so that most memory accesses skip the page table walk. Each lookup presents a virtual address and the address-space identifier of the running context. In the same cycle the block reports hit or miss, the physical address and the permission and attribute bits of the matching mapping. A miss tells the walker to start a table walk. When the walk finishes, the walker writes the result back as a refill.

Every stored mapping carries its own page size, a global flag and the identifier of the context that created it. The tag compare ignores the offset bits that belong to that entry's size, so mappings of 4 KiB, 64 KiB, 1 MiB and 16 MiB share one fully associative array. Mappings that belong to another context simply fail to match, so a context switch needs no flush. Three invalidate forms remove stale mappings: all entries, one context's private entries, or the entries that cover one address.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses, and `lk_paddr`, `lk_perm` and `lk_attr` read zero.
- R2: The lookup is combinational. `lk_hit` is high when `lk_req` is high and a valid entry matches. `lk_miss` is high when `lk_req` is high and no entry matches. When `lk_req` is low, both flags are low. `lk_paddr`, `lk_perm` and `lk_attr` are zero whenever `lk_hit` is low.
- R3: A non-global entry matches only when its stored identifier equals `lk_asid`.
- R4: A global entry (stored with `fill_global`=1) matches under any `lk_asid`.
- R5: `fill_size` selects the number of untranslated low bits: 0 gives 12, 1 gives 16, 2 gives 20 and 3 gives 24. The tag compare and the refill's physical frame both ignore those low bits. The physical address is the stored frame's upper bits joined with the lookup address's low bits.
- R6: A refill takes effect at the next rising clock edge. A lookup in the same cycle as the refill sees the old contents.
- R7: A refill that does not replace an existing entry goes to the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one per such refill, wrapping after the last slot. The seventeenth new mapping in a row therefore evicts the first of them.
- R8: A refill whose size, global flag, identifier (when non-global) and masked virtual page equal those of a valid entry overwrites that entry in place. It does not advance the pointer.
- R9: `inv_en` with `inv_op`=0 clears every entry at the next edge.
- R10: `inv_en` with `inv_op`=1 clears only the non-global entries whose identifier equals `inv_asid`. Global entries survive.
- R11: `inv_en` with `inv_op`=2 clears every entry whose region covers `inv_vaddr`, whatever its identifier or global flag. `inv_op`=3 changes nothing.
- R12: Changing `lk_asid` never removes entries. Switching back to an earlier identifier hits its entries again.
- R13: When several entries match one lookup, the lowest-numbered slot supplies the result.
- R14: When an invalidate and a refill arrive in the same cycle, the invalidate acts on the old contents and the refill is written after it, so the new entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Identifier of the current context |
| lk_hit | output | 1 | A valid entry matches the lookup |
| lk_miss | output | 1 | A lookup was requested and nothing matches; starts a walk |
| lk_paddr | output | PA_W | Translated physical address |
| lk_perm | output | PERM_W | Permission bits of the matching entry |
| lk_attr | output | ATTR_W | Memory attribute bits of the matching entry |
| fill_en | input | 1 | Refill strobe from the walker |
| fill_vaddr | input | VA_W | Virtual address of the refill |
| fill_paddr | input | PA_W | Physical frame of the refill |
| fill_size | input | 2 | Page size code of the refill |
| fill_global | input | 1 | Refill mapping is global |
| fill_asid | input | ASID_W | Identifier of the refill mapping |
| fill_perm | input | PERM_W | Permission bits of the refill |
| fill_attr | input | ATTR_W | Attribute bits of the refill |
| inv_en | input | 1 | Invalidate strobe |
| inv_op | input | 2 | Invalidate kind: 0 all, 1 by identifier, 2 by address, 3 none |
| inv_asid | input | ASID_W | Identifier for invalidate-by-identifier |
| inv_vaddr | input | VA_W | Address for invalidate-by-address |

## Verification
Lookup results are due in the same cycle as their inputs. The bench therefore samples them at the falling edge, after the inputs have settled and before the next rising edge commits any state. Refills and invalidates are due one rising edge after their strobe. The behavioural model applies each one at that same edge, so the model and the design are compared on the same contents in every cycle. Same-cycle cases get their own checks: a lookup during a refill expects the old contents, and an invalidate together with a refill expects the refill to survive.

// File: rtl/atlb_pkg.sv
`timescale 1ns/1ps
package atlb_pkg;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_ADDR = 2'd2,
    INV_NONE = 2'd3
  } inv_op_e;

  localparam int MIN_SHIFT  = 12;
  localparam int SHIFT_STEP = 4;

  // Count of untranslated low address bits for a page size code.
  function automatic int page_shift(input logic [1:0] sz);
    return MIN_SHIFT + SHIFT_STEP * int'(sz);
  endfunction

endpackage

// File: rtl/atlb_tag_match.sv
`timescale 1ns/1ps
module atlb_tag_match
  import atlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int ASID_W = 8
) (
  input  logic              ent_valid,
  input  logic [VA_W-1:0]   ent_vtag,
  input  logic [1:0]        ent_size,
  input  logic              ent_global,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VA_W-1:0]   probe_va,
  input  logic [ASID_W-1:0] probe_asid,
  input  logic              use_asid,
  output logic              match
);

  logic [VA_W-1:0] hi_mask;
  logic            addr_eq;
  logic            scope_ok;

  always_comb begin
    hi_mask  = {VA_W{1'b1}} << page_shift(ent_size);
    addr_eq  = ((ent_vtag ^ probe_va) & hi_mask) == '0;
    scope_ok = !use_asid || ent_global || (ent_asid == probe_asid);
    match    = ent_valid && addr_eq && scope_ok;
  end

endmodule

// File: rtl/atlb_first_pick.sv
`timescale 1ns/1ps
module atlb_first_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins: scan downward so lower indices overwrite.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/atlb_rr_ptr.sv
`timescale 1ns/1ps
module atlb_rr_ptr #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (alloc) begin
      ptr_d = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (alloc) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc |=> $stable(ptr_q)); // R7
  AST_RR_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (ptr_q != $past(ptr_q))); // R7

endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb
  import atlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 16,
  parameter int PERM_W  = 4,
  parameter int ATTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [PERM_W-1:0] lk_perm,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              fill_en,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [PA_W-1:0]   fill_paddr,
  input  logic [1:0]        fill_size,
  input  logic              fill_global,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              inv_en,
  input  logic [1:0]        inv_op,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VA_W-1:0]   inv_vaddr
);

  localparam int IDX_W = $clog2(ENTRIES);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Entry storage: valid bits are reset, payload is not.
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENTRIES-1:0] glob_q;
  logic [VA_W-1:0]    vtag_q  [ENTRIES];
  logic [PA_W-1:0]    pbase_q [ENTRIES];
  logic [1:0]         size_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] inv_cover;
  logic [ENTRIES-1:0] dup_vec;
  logic [ENTRIES-1:0] wr_vec;

  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic               dup_any;
  logic [IDX_W-1:0]   dup_idx;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   fill_slot;
  logic               alloc;
  logic               upd_en;
  logic [VA_W-1:0]    fill_hi_mask;

  assign fill_hi_mask = {VA_W{1'b1}} << page_shift(fill_size);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    atlb_tag_match #(.VA_W(VA_W), .ASID_W(ASID_W)) u_lk_cmp (
      .ent_valid  (valid_q[g]),
      .ent_vtag   (vtag_q[g]),
      .ent_size   (size_q[g]),
      .ent_global (glob_q[g]),
      .ent_asid   (asid_q[g]),
      .probe_va   (lk_vaddr),
      .probe_asid (lk_asid),
      .use_asid   (1'b1),
      .match      (lk_match[g])
    );

    atlb_tag_match #(.VA_W(VA_W), .ASID_W(ASID_W)) u_inv_cmp (
      .ent_valid  (valid_q[g]),
      .ent_vtag   (vtag_q[g]),
      .ent_size   (size_q[g]),
      .ent_global (glob_q[g]),
      .ent_asid   (asid_q[g]),
      .probe_va   (inv_vaddr),
      .probe_asid (inv_asid),
      .use_asid   (1'b0),
      .match      (inv_cover[g])
    );

    // Same mapping already present: same size, scope and masked page.
    assign dup_vec[g] = valid_q[g]
                      && (size_q[g] == fill_size)
                      && (glob_q[g] == fill_global)
                      && (fill_global || (asid_q[g] == fill_asid))
                      && (((vtag_q[g] ^ fill_vaddr) & fill_hi_mask) == '0);

    assign wr_vec[g] = fill_en && (fill_slot == IDX_W'(g));
  end

  atlb_first_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
    .req (lk_match),
    .any (lk_any),
    .idx (lk_idx)
  );

  atlb_first_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_dup_pick (
    .req (dup_vec),
    .any (dup_any),
    .idx (dup_idx)
  );

  atlb_rr_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .alloc (alloc),
    .ptr   (rr_ptr)
  );

  assign alloc     = fill_en && !dup_any;
  assign fill_slot = dup_any ? dup_idx : rr_ptr;
  assign upd_en    = fill_en || inv_en;

  // Next valid state: invalidate on old contents, then refill on top.
  always_comb begin
    valid_d = valid_q;
    if (inv_en) begin
      case (inv_op_e'(inv_op))
        INV_ALL: valid_d = '0;
        INV_ASID: begin
          for (int i = 0; i < ENTRIES; i++) begin
            if (!glob_q[i] && (asid_q[i] == inv_asid)) begin
              valid_d[i] = 1'b0;
            end
          end
        end
        INV_ADDR: valid_d = valid_q & ~inv_cover;
        default: valid_d = valid_q;
      endcase
    end
    valid_d = valid_d | wr_vec;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_vec[i]) begin
        vtag_q[i]  <= fill_vaddr;
        pbase_q[i] <= fill_paddr;
        size_q[i]  <= fill_size;
        glob_q[i]  <= fill_global;
        asid_q[i]  <= fill_asid;
        perm_q[i]  <= fill_perm;
        attr_q[i]  <= fill_attr;
      end
    end
  end

  // Lookup result.
  logic [PA_W-1:0] pa_hi_mask;

  always_comb begin
    lk_hit     = lk_req && lk_any;
    lk_miss    = lk_req && !lk_any;
    pa_hi_mask = {PA_W{1'b1}} << page_shift(size_q[lk_idx]);
    lk_paddr   = '0;
    lk_perm    = '0;
    lk_attr    = '0;
    if (lk_hit) begin
      lk_paddr = (pbase_q[lk_idx] & pa_hi_mask) | (PA_W'(lk_vaddr) & ~pa_hi_mask);
      lk_perm  = perm_q[lk_idx];
      lk_attr  = attr_q[lk_idx];
    end
  end

  // Checks beside the logic they guard.
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(fill_en) && lk_req
     && (lk_vaddr == $past(fill_vaddr))
     && ($past(fill_global) || (lk_asid == $past(fill_asid)))) |-> lk_hit); // R6
  AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (inv_en && (inv_op == 2'd0) && !fill_en) |=> (valid_q == '0)); // R9
  AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !inv_en |=> ((valid_q & $past(valid_q)) == $past(valid_q))); // R12
  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(dup_vec)); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_hit |-> ((lk_paddr == '0) && (lk_perm == '0) && (lk_attr == '0))); // R2

endmodule

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;

  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic        lk_hit;
  logic        lk_miss;
  logic [31:0] lk_paddr;
  logic [3:0]  lk_perm;
  logic [4:0]  lk_attr;
  logic        fill_en;
  logic [31:0] fill_vaddr;
  logic [31:0] fill_paddr;
  logic [1:0]  fill_size;
  logic        fill_global;
  logic [7:0]  fill_asid;
  logic [3:0]  fill_perm;
  logic [4:0]  fill_attr;
  logic        inv_en;
  logic [1:0]  inv_op;
  logic [7:0]  inv_asid;
  logic [31:0] inv_vaddr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  asid_tlb uut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .lk_perm(lk_perm), .lk_attr(lk_attr),
    .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
    .fill_size(fill_size), .fill_global(fill_global), .fill_asid(fill_asid),
    .fill_perm(fill_perm), .fill_attr(fill_attr),
    .inv_en(inv_en), .inv_op(inv_op), .inv_asid(inv_asid), .inv_vaddr(inv_vaddr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference model.
  bit          m_v  [16];
  bit [31:0]   m_va [16];
  bit [31:0]   m_pa [16];
  int          m_sz [16];
  bit          m_g  [16];
  bit [7:0]    m_as [16];
  bit [3:0]    m_pm [16];
  bit [4:0]    m_at [16];
  int          m_ptr = 0;

  function automatic bit [31:0] hmask(input int sz);
    return 32'hFFFF_FFFF << (12 + 4 * sz);
  endfunction

  task automatic model_look(output bit h, output bit [31:0] pa,
                            output bit [3:0] pm, output bit [4:0] at);
    bit found = 0;
    h = 0; pa = 0; pm = 0; at = 0;
    for (int i = 0; i < 16; i++) begin
      if (!found && m_v[i] && (((m_va[i] ^ lk_vaddr) & hmask(m_sz[i])) == 0)
          && (m_g[i] || (m_as[i] == lk_asid))) begin
        found = 1;
        if (lk_req) begin
          h  = 1;
          pa = (m_pa[i] & hmask(m_sz[i])) | (lk_vaddr & ~hmask(m_sz[i]));
          pm = m_pm[i];
          at = m_at[i];
        end
      end
    end
  endtask

  task automatic model_update();
    int tgt = -1;
    if (fill_en) begin
      for (int i = 0; i < 16; i++) begin
        if (tgt < 0 && m_v[i] && m_sz[i] == int'(fill_size) && m_g[i] == fill_global
            && (fill_global || m_as[i] == fill_asid)
            && (((m_va[i] ^ fill_vaddr) & hmask(int'(fill_size))) == 0)) tgt = i;
      end
    end
    if (inv_en) begin
      for (int i = 0; i < 16; i++) begin
        case (inv_op)
          2'd0: m_v[i] = 0;
          2'd1: if (!m_g[i] && m_as[i] == inv_asid) m_v[i] = 0;
          2'd2: if (((m_va[i] ^ inv_vaddr) & hmask(m_sz[i])) == 0) m_v[i] = 0;
          default: ;
        endcase
      end
    end
    if (fill_en) begin
      if (tgt < 0) begin
        tgt = m_ptr;
        m_ptr = (m_ptr + 1) % 16;
      end
      m_v[tgt] = 1; m_va[tgt] = fill_vaddr; m_pa[tgt] = fill_paddr;
      m_sz[tgt] = int'(fill_size); m_g[tgt] = fill_global; m_as[tgt] = fill_asid;
      m_pm[tgt] = fill_perm; m_at[tgt] = fill_attr;
    end
  endtask

  // One clock: compare at the falling edge, commit model at the rising edge.
  task automatic cycle(input string tag, input bit chk, input bit e_hit, input bit [31:0] e_pa);
    bit h; bit [31:0] pa; bit [3:0] pm; bit [4:0] at;
    @(negedge clk);
    model_look(h, pa, pm, at);
    n_chk++;
    if (lk_hit !== h || lk_miss !== (lk_req & ~h) || lk_paddr !== pa
        || lk_perm !== pm || lk_attr !== at) begin
      n_fail++;
      $display("FAIL %s model: hit=%0b miss=%0b pa=%h perm=%h attr=%h expected hit=%0b miss=%0b pa=%h perm=%h attr=%h",
               tag, lk_hit, lk_miss, lk_paddr, lk_perm, lk_attr, h, lk_req & ~h, pa, pm, at);
    end
    if (chk) begin
      n_chk++;
      if (lk_hit !== e_hit || (e_hit && lk_paddr !== e_pa)) begin
        n_fail++;
        $display("FAIL %s direct: hit=%0b pa=%h expected hit=%0b pa=%h",
                 tag, lk_hit, lk_paddr, e_hit, e_pa);
      end
    end
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic set_look(input bit [31:0] va, input bit [7:0] asid);
    lk_req = 1; lk_vaddr = va; lk_asid = asid;
  endtask

  task automatic set_fill(input bit [31:0] va, input bit [31:0] pa, input bit [1:0] sz,
                          input bit g, input bit [7:0] asid);
    fill_en = 1; fill_vaddr = va; fill_paddr = pa; fill_size = sz;
    fill_global = g; fill_asid = asid;
    fill_perm = {g, sz, 1'b1}; fill_attr = asid[4:0];
  endtask

  task automatic fill(input bit [31:0] va, input bit [31:0] pa, input bit [1:0] sz,
                      input bit g, input bit [7:0] asid, input string tag);
    set_fill(va, pa, sz, g, asid);
    cycle(tag, 0, 0, 0);
    fill_en = 0;
  endtask

  task automatic inv(input bit [1:0] op, input bit [7:0] asid, input bit [31:0] va,
                     input string tag);
    inv_en = 1; inv_op = op; inv_asid = asid; inv_vaddr = va;
    cycle(tag, 0, 0, 0);
    inv_en = 0;
  endtask

  task automatic look(input bit [31:0] va, input bit [7:0] asid, input bit e_hit,
                      input bit [31:0] e_pa, input string tag);
    set_look(va, asid);
    cycle(tag, 1, e_hit, e_pa);
  endtask

  initial begin
    rst_n = 0; lk_req = 1; lk_vaddr = 32'h0000_1234; lk_asid = 0;
    fill_en = 0; fill_vaddr = 0; fill_paddr = 0; fill_size = 0; fill_global = 0;
    fill_asid = 0; fill_perm = 0; fill_attr = 0;
    inv_en = 0; inv_op = 0; inv_asid = 0; inv_vaddr = 0;
    // R1: empty during and after reset
    cycle("R1", 1, 0, 0);
    cycle("R1", 1, 0, 0);
    rst_n = 1;
    for (int i = 0; i < 3; i++) cycle("R1", 1, 0, 0);

    // R6: lookup in the refill cycle sees old contents
    set_look(32'h1020_1234, 8'd5);
    set_fill(32'h1020_1000, 32'h8000_5FFF, 2'd0, 0, 8'd5);
    cycle("R6", 1, 0, 0);
    fill_en = 0;
    look(32'h1020_1234, 8'd5, 1, 32'h8000_5234, "R5");
    look(32'h1020_1234, 8'd6, 0, 0, "R3");
    lk_req = 0;
    cycle("R2", 1, 0, 0);

    fill(32'h2030_0000, 32'h4440_0000, 2'd2, 1, 8'd9, "R6");
    look(32'h203A_BCDE, 8'd77, 1, 32'h444A_BCDE, "R4");
    look(32'h2040_0000, 8'd9, 0, 0, "R5");
    fill(32'h3001_0000, 32'h00AB_0000, 2'd1, 0, 8'd5, "R6");
    look(32'h3001_FFFC, 8'd5, 1, 32'h00AB_FFFC, "R5");
    fill(32'h4100_0000, 32'hC200_0000, 2'd3, 0, 8'd3, "R6");
    look(32'h41FE_DCBA, 8'd3, 1, 32'hC2FE_DCBA, "R5");

    // R12: switching context and back keeps entries
    look(32'h1020_1234, 8'd6, 0, 0, "R12");
    look(32'h1020_1234, 8'd5, 1, 32'h8000_5234, "R12");

    // R8: refill of an existing mapping replaces it in place
    fill(32'h1020_1000, 32'h9000_9000, 2'd0, 0, 8'd5, "R8");
    look(32'h1020_1234, 8'd5, 1, 32'h9000_9234, "R8");

    // R13: overlapping 1M global in slot 1 beats 4K in slot 4
    fill(32'h2031_2000, 32'h5551_2000, 2'd0, 0, 8'd9, "R13");
    look(32'h2031_2345, 8'd9, 1, 32'h4441_2345, "R13");

    // R10: invalidate by identifier
    inv(2'd1, 8'd5, 0, "R10");
    look(32'h1020_1234, 8'd5, 0, 0, "R10");
    look(32'h3001_FFFC, 8'd5, 0, 0, "R10");
    look(32'h203A_BCDE, 8'd5, 1, 32'h444A_BCDE, "R10");
    look(32'h41FE_DCBA, 8'd3, 1, 32'hC2FE_DCBA, "R10");
    inv(2'd1, 8'd9, 0, "R10");
    look(32'h2031_2345, 8'd9, 1, 32'h4441_2345, "R10");

    // R11: invalidate by address, and the null code
    inv(2'd3, 8'd3, 32'h4180_0000, "R11");
    look(32'h41FE_DCBA, 8'd3, 1, 32'hC2FE_DCBA, "R11");
    inv(2'd2, 8'd0, 32'h4180_0000, "R11");
    look(32'h41FE_DCBA, 8'd3, 0, 0, "R11");
    inv(2'd2, 8'd0, 32'h2039_9999, "R11");
    look(32'h203A_BCDE, 8'd5, 0, 0, "R11");

    // R14: invalidate-all together with a refill
    set_fill(32'h5000_0000, 32'h1234_5000, 2'd0, 0, 8'd1);
    inv_en = 1; inv_op = 2'd0;
    cycle("R14", 0, 0, 0);
    fill_en = 0; inv_en = 0;
    look(32'h5000_0ABC, 8'd1, 1, 32'h1234_5ABC, "R14");

    // R9: invalidate-all alone
    inv(2'd0, 8'd0, 0, "R9");
    look(32'h5000_0ABC, 8'd1, 0, 0, "R9");

    // R7: seventeen new mappings evict the first
    for (int i = 0; i < 17; i++)
      fill(32'h6000_0000 + (i << 12), 32'h7000_0000 + (i << 12), 2'd0, 0, 8'd2, "R7");
    look(32'h6000_0010, 8'd2, 0, 0, "R7");
    look(32'h6000_1010, 8'd2, 1, 32'h7000_1010, "R7");
    look(32'h6001_0010, 8'd2, 1, 32'h7001_0010, "R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule